// File: doc/BRIEF.md
# Host Event SCI/SMI Generator

This block turns a 32-bit vector of host events into the interrupt signalling a host chipset expects. Three mask vectors pick which events raise a system management interrupt (SMI), which raise a system control interrupt (SCI), and which drive a wake request. An update strobe tells the block that the events or the masks have changed. On that strobe it re-evaluates both pending status bits and the wake level, and it queues active-low pulses on the SMI and SCI lines.

An SMI pulse marks only the transition into SMI-pending. An SCI pulse is raised on every update that finds a masked SCI event. A mailbox can also ask for an SCI after each transaction it completes. Both interrupt lines go through one pulse sequencer. It never drives the two lines low at the same time, it sends the SMI first when both are due, and it absorbs a request for a line whose pulse is already running.

Nothing happens until firmware reports that initialization is complete. Before that, every output holds its idle value and all requests are discarded.

Top module: `host_evt_gen`

## Requirements
- R1: Until `init_done_i` has been sampled high at a clock edge, all outputs stay idle: pending bits 0, wake 0, pulse lines 1. Update strobes and mailbox requests seen up to and including that edge are discarded. Once enabled, the block stays enabled until reset.
- R2: An enabled update sets `smi_pend_o` to the OR-reduction of `events_i & smi_mask_i`. The new value is visible on the clock after the strobe, and the bit holds between updates.
- R3: An enabled update sets `sci_pend_o` to the OR-reduction of `events_i & sci_mask_i`. It follows the same timing and hold rule as R2.
- R4: An update requests an SMI pulse only when its SMI term is nonzero and `smi_pend_o` was 0 just before that update.
- R5: Every enabled update whose SCI term is nonzero requests an SCI pulse, whatever the previous value of `sci_pend_o`.
- R6: `wake_o` is loaded with the OR-reduction of `events_i & wake_mask_i` on each enabled update and holds between updates.
- R7: An enabled cycle with `mbx_sci_req_i` high requests an SCI pulse.
- R8: Each pulse drives its line low for exactly PULSE_LEN clocks (default 4). An idle sequencer starts the pulse on the clock after the request.
- R9: The two lines are never low together. When SMI and SCI are both waiting, SMI goes first. A waiting pulse starts on the clock that the running pulse ends.
- R10: A request for the line whose pulse is running is merged into that pulse and produces no extra pulse. A request for the other line waits until the running pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | Initialization complete; enables the block from the next clock |
| update_i | input | 1 | Re-evaluate events and masks |
| events_i | input | 32 | Host event vector |
| smi_mask_i | input | 32 | Events that raise SMI |
| sci_mask_i | input | 32 | Events that raise SCI |
| wake_mask_i | input | 32 | Events that request wake |
| mbx_sci_req_i | input | 1 | Mailbox transaction done, asks for an SCI |
| smi_pend_o | output | 1 | SMI pending status |
| sci_pend_o | output | 1 | SCI pending status |
| smi_n_o | output | 1 | SMI line, active-low pulse |
| sci_n_o | output | 1 | SCI line, active-low pulse |
| wake_o | output | 1 | Wake request level |

## Verification
The hardest situations to reach are a request arriving while the other line's pulse is still running, and a request for the running line landing on that pulse's last clock. Either one needs update strobes and mailbox requests packed within a few clocks of each other. The random phase therefore fires updates and mailbox requests densely. It draws masks that are all-zero or all-one often, so that both pulses come due together and queue behind one another. Directed cases cover the SMI first-edge rule and the merge.

// File: rtl/hevt_pkg.sv
package hevt_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SMI  = 2'd1,
    SEQ_SCI  = 2'd2
  } seq_state_e;

  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CH_SMI  = 0;
  localparam int unsigned CH_SCI  = 1;
  localparam int unsigned CH_WAKE = 2;
endpackage

// File: rtl/hevt_enable.sv
module hevt_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else if (init_done_i) en_q <= 1'b1;
  end

  assign en_o = en_q;
endmodule

// File: rtl/hevt_eval.sv
module hevt_eval
  import hevt_pkg::*;
#(
  parameter int unsigned EVT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             update_i,
  input  logic [EVT_W-1:0] events_i,
  input  logic [EVT_W-1:0] smi_mask_i,
  input  logic [EVT_W-1:0] sci_mask_i,
  input  logic [EVT_W-1:0] wake_mask_i,
  output logic             smi_pend_o,
  output logic             sci_pend_o,
  output logic             wake_o,
  output logic             smi_fire_o,
  output logic             sci_fire_o
);
  logic [EVT_W-1:0] mask_arr [NUM_CH];
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] stat_q;
  logic              take;

  assign mask_arr[CH_SMI]  = smi_mask_i;
  assign mask_arr[CH_SCI]  = sci_mask_i;
  assign mask_arr[CH_WAKE] = wake_mask_i;
  assign take = en_i & update_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hit[c] = |(events_i & mask_arr[c]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[c] <= 1'b0;
      else if (take) stat_q[c] <= hit[c];
    end
  end

  // SMI marks only the edge into pending; SCI fires on each hit
  assign smi_fire_o = take & hit[CH_SMI] & ~stat_q[CH_SMI];
  assign sci_fire_o = take & hit[CH_SCI];

  assign smi_pend_o = stat_q[CH_SMI];
  assign sci_pend_o = stat_q[CH_SCI];
  assign wake_o     = stat_q[CH_WAKE];
endmodule

// File: rtl/hevt_pulse_seq.sv
module hevt_pulse_seq
  import hevt_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smi_req_i,
  input  logic sci_req_i,
  output logic smi_n_o,
  output logic sci_n_o
);
  localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             smi_q, smi_d, sci_q, sci_d;
  logic             smi_want, sci_want, last;

  assign smi_want = smi_q | smi_req_i;
  assign sci_want = sci_q | sci_req_i;
  assign last     = (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    smi_d   = smi_q;
    sci_d   = sci_q;
    unique case (state_q)
      SEQ_IDLE: begin
        cnt_d = '0;
        if (smi_want) begin
          state_d = SEQ_SMI;
          smi_d   = 1'b0;
          sci_d   = sci_want;
        end else if (sci_want) begin
          state_d = SEQ_SCI;
          sci_d   = 1'b0;
        end
      end
      SEQ_SMI: begin
        smi_d = 1'b0;              // merged into running pulse
        sci_d = sci_want;
        if (!last) begin
          cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d = '0;
          if (sci_want) begin
            state_d = SEQ_SCI;
            sci_d   = 1'b0;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      SEQ_SCI: begin
        sci_d = 1'b0;              // merged into running pulse
        smi_d = smi_want;
        if (!last) begin
          cnt_d = cnt_q + 1'b1;
        end else begin
          cnt_d = '0;
          if (smi_want) begin
            state_d = SEQ_SMI;
            smi_d   = 1'b0;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
        smi_d   = 1'b0;
        sci_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      smi_q   <= 1'b0;
      sci_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      smi_q   <= smi_d;
      sci_q   <= sci_d;
    end
  end

  assign smi_n_o = (state_q != SEQ_SMI);
  assign sci_n_o = (state_q != SEQ_SCI);
endmodule

// File: rtl/host_evt_gen.sv
module host_evt_gen #(
  parameter int unsigned EVT_W     = 32,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic             update_i,
  input  logic [EVT_W-1:0] events_i,
  input  logic [EVT_W-1:0] smi_mask_i,
  input  logic [EVT_W-1:0] sci_mask_i,
  input  logic [EVT_W-1:0] wake_mask_i,
  input  logic             mbx_sci_req_i,
  output logic             smi_pend_o,
  output logic             sci_pend_o,
  output logic             smi_n_o,
  output logic             sci_n_o,
  output logic             wake_o
);
  logic en;
  logic smi_fire, sci_fire, sci_req;

  hevt_enable u_en (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_done_i(init_done_i),
    .en_o       (en)
  );

  hevt_eval #(.EVT_W(EVT_W)) u_eval (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .update_i   (update_i),
    .events_i   (events_i),
    .smi_mask_i (smi_mask_i),
    .sci_mask_i (sci_mask_i),
    .wake_mask_i(wake_mask_i),
    .smi_pend_o (smi_pend_o),
    .sci_pend_o (sci_pend_o),
    .wake_o     (wake_o),
    .smi_fire_o (smi_fire),
    .sci_fire_o (sci_fire)
  );

  assign sci_req = sci_fire | (en & mbx_sci_req_i);

  hevt_pulse_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smi_req_i(smi_fire),
    .sci_req_i(sci_req),
    .smi_n_o  (smi_n_o),
    .sci_n_o  (sci_n_o)
  );
endmodule

// File: rtl/hevt_chk.sv
module hevt_chk #(
  parameter int unsigned EVT_W     = 32,
  parameter int unsigned PULSE_LEN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en,
  input logic             update_i,
  input logic [EVT_W-1:0] events_i,
  input logic [EVT_W-1:0] smi_mask_i,
  input logic [EVT_W-1:0] sci_mask_i,
  input logic [EVT_W-1:0] wake_mask_i,
  input logic             smi_pend_o,
  input logic             sci_pend_o,
  input logic             smi_n_o,
  input logic             sci_n_o,
  input logic             wake_o
);
  int unsigned smi_lo, sci_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_lo <= 0;
      sci_lo <= 0;
    end else begin
      smi_lo <= smi_n_o ? 0 : smi_lo + 1;
      sci_lo <= sci_n_o ? 0 : sci_lo + 1;
    end
  end

  // R1
  idle_before_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (smi_n_o && sci_n_o && !smi_pend_o && !sci_pend_o && !wake_o));

  // R2
  smi_pend_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && update_i) |=> (smi_pend_o == $past(|(events_i & smi_mask_i))));

  // R3
  sci_pend_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && update_i) |=> (sci_pend_o == $past(|(events_i & sci_mask_i))));

  // R6
  wake_eval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && update_i) |=> (wake_o == $past(|(events_i & wake_mask_i))));

  // R2
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en && update_i) |=> ($stable(smi_pend_o) && $stable(sci_pend_o) && $stable(wake_o)));

  // R8
  smi_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smi_n_o) |-> (smi_lo == PULSE_LEN));

  // R8
  sci_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sci_n_o) |-> (sci_lo == PULSE_LEN));

  // R9
  one_line_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smi_n_o || sci_n_o));
endmodule

bind host_evt_gen hevt_chk #(.EVT_W(EVT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en         (en),
  .update_i   (update_i),
  .events_i   (events_i),
  .smi_mask_i (smi_mask_i),
  .sci_mask_i (sci_mask_i),
  .wake_mask_i(wake_mask_i),
  .smi_pend_o (smi_pend_o),
  .sci_pend_o (sci_pend_o),
  .smi_n_o    (smi_n_o),
  .sci_n_o    (sci_n_o),
  .wake_o     (wake_o)
);

// File: tb/sim_host_evt_gen.sv
`timescale 1ns/1ps
module sim_host_evt_gen;
  localparam int LEN = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_done = 1'b0, upd = 1'b0, mbx = 1'b0;
  logic [31:0] evts = '0, smi_m = '0, sci_m = '0, wake_m = '0;
  logic        smi_pend, sci_pend, smi_n, sci_n, wake;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  host_evt_gen #(.EVT_W(32), .PULSE_LEN(LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .update_i(upd),
    .events_i(evts), .smi_mask_i(smi_m), .sci_mask_i(sci_m), .wake_mask_i(wake_m),
    .mbx_sci_req_i(mbx), .smi_pend_o(smi_pend), .sci_pend_o(sci_pend),
    .smi_n_o(smi_n), .sci_n_o(sci_n), .wake_o(wake)
  );

  // reference model built from the requirements
  bit m_en, m_smi_p, m_sci_p, m_wake, m_smi_q, m_sci_q;
  int m_st, m_cnt;

  function automatic bit hit(logic [31:0] e, logic [31:0] m);
    return (e & m) != 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit sn, cn, sw, cw;
    if (!rst_n) begin
      m_en <= 0; m_smi_p <= 0; m_sci_p <= 0; m_wake <= 0;
      m_smi_q <= 0; m_sci_q <= 0; m_st <= 0; m_cnt <= 0;
    end else begin
      sn = 0; cn = 0;
      if (m_en && upd) begin
        m_smi_p <= hit(evts, smi_m);
        m_sci_p <= hit(evts, sci_m);
        m_wake  <= hit(evts, wake_m);
        sn = hit(evts, smi_m) && !m_smi_p;
        cn = hit(evts, sci_m);
      end
      if (m_en && mbx) cn = 1;
      m_en <= m_en | init_done;
      sw = m_smi_q | sn;
      cw = m_sci_q | cn;
      if (m_st == 0) begin
        m_cnt <= 0;
        if (sw) begin m_st <= 1; m_smi_q <= 0; m_sci_q <= cw; end
        else if (cw) begin m_st <= 2; m_sci_q <= 0; end
      end else if (m_st == 1) begin
        m_smi_q <= 0; m_sci_q <= cw;
        if (m_cnt < LEN - 1) m_cnt <= m_cnt + 1;
        else begin
          m_cnt <= 0;
          if (cw) begin m_st <= 2; m_sci_q <= 0; end else m_st <= 0;
        end
      end else begin
        m_sci_q <= 0; m_smi_q <= sw;
        if (m_cnt < LEN - 1) m_cnt <= m_cnt + 1;
        else begin
          m_cnt <= 0;
          if (sw) begin m_st <= 1; m_smi_q <= 0; end else m_st <= 0;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(smi_pend == m_smi_p, m_en ? "R2 smi_pend" : "R1 smi_pend", smi_pend, m_smi_p);
      chk(sci_pend == m_sci_p, m_en ? "R3 sci_pend" : "R1 sci_pend", sci_pend, m_sci_p);
      chk(smi_n == (m_st != 1), "R4 smi_n", smi_n, m_st != 1);
      chk(sci_n == (m_st != 2), "R5 sci_n", sci_n, m_st != 2);
      chk(wake == m_wake, "R6 wake", wake, m_wake);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_upd(logic [31:0] e);
    evts = e; upd = 1'b1;
    step(1);
    upd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lows;
    void'($urandom(32'd5150));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(smi_n && sci_n && !smi_pend && !sci_pend && !wake, "R1 reset", 0, 0);

    // R1: strobes before init are discarded
    smi_m = 32'h1; sci_m = 32'h1; wake_m = 32'h1;
    mbx = 1'b1; do_upd(32'h1); mbx = 1'b0;
    step(LEN + 2);
    chk(smi_n && sci_n && !smi_pend && !sci_pend && !wake, "R1 ignored", smi_n, 1);

    init_done = 1'b1;
    step(1);
    init_done = 1'b0;  // R1: enable is sticky

    // R9: both due, SMI first, SCI right after
    evts = 32'h1; upd = 1'b1;
    step(1);
    upd = 1'b0;
    chk(!smi_n && sci_n, "R9 smi first", smi_n, 0);
    chk(smi_pend && sci_pend, "R2 R3 pend set", smi_pend, 1);
    step(LEN);
    chk(smi_n && !sci_n, "R9 sci follows", sci_n, 0);
    step(LEN + 2);

    // R4: SMI already pending, no new SMI; R5 SCI again
    evts = 32'h1; upd = 1'b1;
    step(1);
    upd = 1'b0;
    chk(smi_n, "R4 no repeat smi", smi_n, 1);
    chk(!sci_n, "R5 sci every update", sci_n, 0);
    step(LEN + 2);

    // R2/R3 clear
    do_upd(32'h0);
    chk(!smi_pend && !sci_pend, "R2 R3 cleared", smi_pend, 0);
    step(2);

    // R7 mailbox + R10 merge of a second request during the pulse
    mbx = 1'b1; step(1); mbx = 1'b0;
    chk(!sci_n, "R7 mbx sci", sci_n, 0);
    mbx = 1'b1; step(1); mbx = 1'b0;
    lows = (sci_n ? 0 : 1) + 1;
    for (int i = 0; i < 3 * LEN; i++) begin
      step(1);
      if (!sci_n) lows++;
    end
    // R8 width and R10 merge
    chk(lows == LEN, "R10 merged pulse", lows, LEN);

    // R6 wake level and hold
    wake_m = 32'h8000_0000; smi_m = '0; sci_m = '0;
    do_upd(32'h8000_0000);
    chk(wake, "R6 wake set", wake, 1);
    evts = '0; step(2);
    chk(wake, "R6 wake hold", wake, 1);
    step(LEN * 3);

    // constrained random: dense updates and mailbox requests
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 4;
      smi_m  = (r == 0) ? '0 : (r == 1) ? '1 : $urandom;
      r = $urandom % 4;
      sci_m  = (r == 0) ? '0 : (r == 1) ? '1 : $urandom;
      wake_m = $urandom;
      evts   = ($urandom % 3 == 0) ? '0 : ($urandom & $urandom & $urandom);
      upd    = ($urandom % 3 == 0);
      mbx    = ($urandom % 6 == 0);
      step(1);
    end
    upd = 1'b0; mbx = 1'b0;
    step(4 * LEN);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule